// File: doc/BRIEF.md
# Programmable Divided Countdown Timer

This block is a 32-bit down-counter fed by a power-of-two prescaler. Software sets it up through a small word-wide register port. It writes a control word that holds an interrupt vector, a delivery-mode code, a mask bit and a periodic-mode bit. It writes a divide code that selects the prescale ratio. Writing a start value arms the timer, and the live count can be read back at any time.

When the count expires, the block raises a one-clock pulse carrying the 8-bit vector and the 3-bit mode code, unless the mask bit is set. A downstream interrupt controller consumes that pulse. In one-shot mode the counter stops at zero after a single expiry. In periodic mode it reloads the start value and keeps running, with a period of start value plus one prescaled ticks.

Top module: `dct_timer`

## Requirements
- R1: The divide register sits at address 3. A write keeps only data bits 3, 1 and 0 (data AND 0xB). With s = ({bit3,bit1,bit0} + 1) mod 8, the prescale ratio is 2^s. The code 0xB gives divide by 1, 0x1 gives divide by 4 and 0x8 gives divide by 32.
- R2: A write to the start-value register (address 2'd1) loads the counter with the written value on that clock edge and restarts the prescaler phase. An expiry pending from the earlier start value is dropped.
- R3: In one-shot mode (control bit 17 = 0), the count falls by one on each prescaled tick and then holds at 0. Exactly one pulse appears, in the cycle after clock edge W + ratio*(N+1), where W is the edge of the start-value write and N is the start value. A start value of 0 produces no pulse.
- R4: In periodic mode (control bit 17 = 1), the count runs from N down to 0 and reloads N on the next tick. A pulse appears after edges W + k*ratio*(N+1) for k = 1, 2, and so on.
- R5: In periodic mode, a start value of 0 produces no pulse, and the count stays 0.
- R6: The control register sits at address 0. Bit 17 selects periodic mode, bit 16 masks the pulse, bits 10:8 are the mode code driven on `fire_mode`, and bits 7:0 are the vector driven on `fire_vec`. All other bits read back as 0.
- R7: After reset, the control register reads 0x00010000, and the start value, current count and divide register read 0. `fire` is low.
- R8: While the mask bit is set, the counter keeps running but no pulse is raised. Clearing the mask gives a pulse at the next expiry only, with no replay of expiries missed while masked.
- R9: `fire` is high for exactly one clock per expiry.
- R10: Address 2 returns the live count. Writes to address 2 have no effect on the count or on when the pulse fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 start value, 2 current count, 3 divide) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 32 | Combinational read data |
| fire | output | 1 | One-clock expiry pulse |
| fire_vec | output | 8 | Vector accompanying the pulse |
| fire_mode | output | 3 | Delivery-mode code accompanying the pulse |

## Verification
The assertions assume that `wr_en`, `wr_addr` and `wr_data` are known and stable around each rising edge after reset. They also assume that a start-value write and a tick may coincide, with the write taking precedence. The stimulus changes inputs only on falling edges and keeps every address inside the four-entry map. Every periodic start value is at least 1, except where R5 is being checked, so expiries are never back to back. The bench predicts each pulse's edge from the written start value and divide code. It stops periodic runs with a zero start-value write before any unscheduled expiry.

// File: rtl/dct_pkg.sv
package dct_pkg;
   localparam int DATA_W   = 32;
   localparam int VEC_W    = 8;
   localparam int MODE_W   = 3;
   localparam int SHIFT_W  = 3;
   localparam int DIV_W    = 4;
   localparam int VEC_LSB  = 0;
   localparam int MODE_LSB = 8;
   localparam int MASK_BIT = 16;
   localparam int PER_BIT  = 17;
   localparam logic [DIV_W-1:0] DIV_KEEP = 4'hB;

   typedef enum logic [1:0] {
      A_CTRL = 2'd0,
      A_INIT = 2'd1,
      A_CURR = 2'd2,
      A_DIV  = 2'd3
   } reg_addr_e;

   typedef struct packed {
      logic              periodic;
      logic              masked;
      logic [MODE_W-1:0] mode;
      logic [VEC_W-1:0]  vec;
   } ctrl_t;

   // Non-contiguous divide code: bit3 becomes the top bit of a 3-bit field.
   function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [DIV_W-1:0] code);
      logic [SHIFT_W-1:0] joined;
      joined = {code[3], code[1:0]};
      return joined + SHIFT_W'(1);
   endfunction
endpackage

// File: rtl/dct_regs.sv
module dct_regs
   import dct_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output ctrl_t             ctrl,
   output logic [DIV_W-1:0]  div_cfg,
   output logic [CNT_W-1:0]  init_val,
   output logic              load
);
   logic hit_ctrl, hit_div;

   assign load     = wr_en && (reg_addr_e'(wr_addr) == A_INIT);
   assign hit_ctrl = wr_en && (reg_addr_e'(wr_addr) == A_CTRL);
   assign hit_div  = wr_en && (reg_addr_e'(wr_addr) == A_DIV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl     <= '{periodic: 1'b0, masked: 1'b1, mode: '0, vec: '0};
         div_cfg  <= '0;
         init_val <= '0;
      end else begin
         if (hit_ctrl) begin
            ctrl.periodic <= wr_data[PER_BIT];
            ctrl.masked   <= wr_data[MASK_BIT];
            ctrl.mode     <= wr_data[MODE_LSB +: MODE_W];
            ctrl.vec      <= wr_data[VEC_LSB +: VEC_W];
         end
         if (hit_div)
            div_cfg <= wr_data[DIV_W-1:0] & DIV_KEEP;
         if (load)
            init_val <= wr_data[CNT_W-1:0];
      end
   end

   a_r1_div_keep: assert property (@(posedge clk) disable iff (!rst_n)
      hit_div |=> div_cfg == ($past(wr_data[DIV_W-1:0]) & 4'hB));
   a_r6_ctrl_vec: assert property (@(posedge clk) disable iff (!rst_n)
      hit_ctrl |=> ctrl.vec == $past(wr_data[VEC_W-1:0]));
endmodule

// File: rtl/dct_prescale.sv
module dct_prescale
   import dct_pkg::*;
#(
   parameter int SW = SHIFT_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic [SW-1:0] shift,
   output logic          tick
);
   localparam int PRE_W = (1 << SW) - 1;

   logic [PRE_W-1:0] pre_cnt;
   logic [PRE_W-1:0] lo_mask;

   initial assert (SW >= 1 && SW <= 4) else $error("dct_prescale: SW out of range");

   for (genvar g = 0; g < PRE_W; g++) begin : g_mask
      assign lo_mask[g] = (shift > SW'(g));
   end

   assign tick = ((pre_cnt & lo_mask) == lo_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre_cnt <= '0;
      else if (restart) pre_cnt <= '0;
      else              pre_cnt <= pre_cnt + PRE_W'(1);
   end

   a_r1_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !restart && shift != '0) |=> (!tick || shift != $past(shift)));
   a_r2_phase_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && shift != '0) |=> !tick || shift != $past(shift));
endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] init_val,
   input  logic             tick,
   input  logic             periodic,
   output logic [CNT_W-1:0] cur,
   output logic             expire
);
   logic armed;
   logic at_zero;

   assign at_zero = (cur == '0);
   assign expire  = tick && !load && at_zero &&
                    (periodic ? (init_val != '0) : armed);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur   <= '0;
         armed <= 1'b0;
      end else if (load) begin
         cur   <= load_val;
         armed <= (load_val != '0);
      end else if (tick) begin
         if (!at_zero)
            cur <= cur - CNT_W'(1);
         else if (periodic)
            cur <= init_val;
         else
            armed <= 1'b0;
      end
   end

   a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cur == $past(load_val));
   a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && cur != '0) |=> cur == $past(cur) - CNT_W'(1));
   a_r3_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!periodic && cur == '0 && !load) |=> cur == '0);
   a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && periodic && cur == '0) |=> cur == $past(init_val));
   a_r5_zero_period: assert property (@(posedge clk) disable iff (!rst_n)
      (periodic && init_val == '0 && !load) |=> cur == '0);
endmodule

// File: rtl/dct_timer.sv
module dct_timer
   import dct_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [1:0]        rd_addr,
   output logic [31:0]       rd_data,
   output logic              fire,
   output logic [7:0]        fire_vec,
   output logic [2:0]        fire_mode
);
   ctrl_t              ctrl;
   logic [DIV_W-1:0]   div_cfg;
   logic [CNT_W-1:0]   init_val;
   logic [CNT_W-1:0]   cur;
   logic               load, tick, expire;
   logic [SHIFT_W-1:0] shift;
   logic [31:0]        ctrl_word;

   initial assert (CNT_W >= 2 && CNT_W <= DATA_W) else $error("dct_timer: CNT_W out of range");

   dct_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ctrl(ctrl), .div_cfg(div_cfg), .init_val(init_val), .load(load));

   assign shift = div_to_shift(div_cfg);

   dct_prescale #(.SW(SHIFT_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .restart(load), .shift(shift), .tick(tick));

   dct_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(wr_data[CNT_W-1:0]),
      .init_val(init_val), .tick(tick), .periodic(ctrl.periodic),
      .cur(cur), .expire(expire));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fire      <= 1'b0;
         fire_vec  <= '0;
         fire_mode <= '0;
      end else begin
         fire <= expire && !ctrl.masked;
         if (expire) begin
            fire_vec  <= ctrl.vec;
            fire_mode <= ctrl.mode;
         end
      end
   end

   always_comb begin
      ctrl_word = '0;
      ctrl_word[PER_BIT]                = ctrl.periodic;
      ctrl_word[MASK_BIT]               = ctrl.masked;
      ctrl_word[MODE_LSB +: MODE_W]     = ctrl.mode;
      ctrl_word[VEC_LSB +: VEC_W]       = ctrl.vec;
   end

   always_comb begin
      case (reg_addr_e'(rd_addr))
         A_CTRL:  rd_data = ctrl_word;
         A_INIT:  rd_data = 32'(init_val);
         A_CURR:  rd_data = 32'(cur);
         A_DIV:   rd_data = 32'(div_cfg);
         default: rd_data = '0;
      endcase
   end

   a_r8_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && ctrl.masked) |=> !fire);
   a_r9_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);
   a_r10_curr_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd2 && !tick) |=> cur == $past(cur));
endmodule

// File: tb/sim_dct_timer.sv
module sim_dct_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        fire;
   logic [7:0]  fire_vec;
   logic [2:0]  fire_mode;

   always #10 clk = ~clk;

   dct_timer u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .fire(fire), .fire_vec(fire_vec),
      .fire_mode(fire_mode));

   typedef struct {
      int         at;
      logic [7:0] vec;
      logic [2:0] mode;
      string      req;
   } exp_t;

   exp_t sbq[$];
   int   cyc = 0;
   int   checks = 0;
   int   fails = 0;
   bit   done = 1'b0;
   logic prev_fire = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   // Monitor: compare each pulse against the scoreboard head.
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_fire) chk(!fire, "R9", "pulse wider than one clock", fire, 0);
         if (fire) begin
            if (sbq.size() == 0) chk(1'b0, "R8", "unexpected pulse at cycle", cyc, -1);
            else begin
               exp_t e;
               e = sbq.pop_front();
               chk(cyc == e.at, e.req, "pulse cycle", cyc, e.at);
               chk(fire_vec == e.vec && fire_mode == e.mode, e.req, "vector/mode",
                   {fire_mode, fire_vec}, {e.mode, e.vec});
            end
         end
         prev_fire <= fire;
      end
   end

   task automatic push(input int at, input logic [7:0] v, input logic [2:0] m, input string req);
      exp_t e;
      e.at = at; e.vec = v; e.mode = m; e.req = req;
      sbq.push_back(e);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d, output int edge_cyc);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      edge_cyc = cyc + 1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input logic [1:0] a, input logic [31:0] expv,
                         input string req, input string what);
      rd_addr = a;
      #1;
      chk(rd_data == expv, req, what, rd_data, expv);
   endtask

   task automatic wait_cyc(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         chk(1'b0, "WD", "watchdog expired", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int c0, c1, dummy;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R7 reset state
      rd_chk(2'd0, 32'h0001_0000, "R7", "control after reset");
      rd_chk(2'd1, 32'h0, "R7", "start value after reset");
      rd_chk(2'd2, 32'h0, "R7", "count after reset");
      rd_chk(2'd3, 32'h0, "R7", "divide after reset");
      chk(fire == 1'b0, "R7", "fire after reset", fire, 0);

      // R1 divide mask and R6 field readback
      wr(2'd3, 32'hFFFF_FFFF, dummy);
      rd_chk(2'd3, 32'hB, "R1", "divide keeps bits 3,1,0");
      wr(2'd0, 32'hFFFF_FFFF, dummy);
      rd_chk(2'd0, 32'h0003_07FF, "R6", "control unused bits read 0");

      // R3 one-shot, divide by 1
      wr(2'd0, 32'h0000_0342, dummy);
      wr(2'd3, 32'hB, dummy);
      wr(2'd1, 32'd5, c0);
      push(c0 + 6, 8'h42, 3'd3, "R3");
      wait_cyc(c0 + 3);
      rd_chk(2'd2, 32'd2, "R3", "count mid one-shot");
      wait_cyc(c0 + 20);
      rd_chk(2'd2, 32'd0, "R3", "count holds at zero");

      // R1 divide by 4
      wr(2'd3, 32'h1, dummy);
      wr(2'd1, 32'd3, c0);
      push(c0 + 16, 8'h42, 3'd3, "R1");
      wait_cyc(c0 + 5);
      rd_chk(2'd2, 32'd2, "R1", "count after one /4 tick");
      wait_cyc(c0 + 20);

      // R1 divide by 32 via bit 3
      wr(2'd3, 32'h8, dummy);
      wr(2'd1, 32'd2, c0);
      push(c0 + 96, 8'h42, 3'd3, "R1");
      wait_cyc(c0 + 40);
      rd_chk(2'd2, 32'd1, "R1", "count after one /32 tick");
      wait_cyc(c0 + 100);

      // R4 periodic, then R5 zero start value
      wr(2'd3, 32'hB, dummy);
      wr(2'd0, 32'h0002_0555, dummy);
      wr(2'd1, 32'd2, c0);
      push(c0 + 3, 8'h55, 3'd5, "R4");
      push(c0 + 6, 8'h55, 3'd5, "R4");
      push(c0 + 9, 8'h55, 3'd5, "R4");
      wait_cyc(c0 + 4);
      rd_chk(2'd2, 32'd1, "R4", "count after reload");
      wait_cyc(c0 + 10);
      wr(2'd1, 32'd0, c1);
      wait_cyc(c1 + 30);
      rd_chk(2'd2, 32'd0, "R5", "periodic zero stays idle");
      chk(sbq.size() == 0, "R4", "periodic pulses outstanding", sbq.size(), 0);

      // R2 restart drops the earlier expiry
      wr(2'd0, 32'h0000_0342, dummy);
      wr(2'd1, 32'd10, c0);
      wait_cyc(c0 + 4);
      wr(2'd1, 32'd3, c1);
      push(c1 + 4, 8'h42, 3'd3, "R2");
      wait_cyc(c1 + 20);

      // R8 masked periodic, then unmask without replay
      wr(2'd0, 32'h0003_0177, dummy);
      wr(2'd1, 32'd3, c0);
      wait_cyc(c0 + 6);
      rd_chk(2'd2, 32'd1, "R8", "masked timer keeps counting");
      wait_cyc(c0 + 9);
      wr(2'd0, 32'h0002_0177, dummy);
      push(c0 + 12, 8'h77, 3'd1, "R8");
      push(c0 + 16, 8'h77, 3'd1, "R8");
      wait_cyc(c0 + 17);
      wr(2'd1, 32'd0, dummy);
      wait_cyc(c0 + 30);
      chk(sbq.size() == 0, "R8", "unmasked pulses outstanding", sbq.size(), 0);

      // R10 current-count writes ignored
      wr(2'd0, 32'h0000_0342, dummy);
      wr(2'd1, 32'd20, c0);
      wait_cyc(c0 + 5);
      wr(2'd2, 32'd7, dummy);
      rd_chk(2'd2, 32'd14, "R10", "count after ignored write");
      push(c0 + 21, 8'h42, 3'd3, "R10");
      wait_cyc(c0 + 30);

      chk(sbq.size() == 0, "R3", "pulses outstanding at end", sbq.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule